// File: doc/BRIEF.md
# Serial-Input Radix-4/2 Butterfly Adder

This block performs the add/subtract half of an FFT butterfly on complex samples that arrive one per load strobe through a single 32-bit port. Each sample is one word. The real part sits in the low half and the imaginary part in the high half, and both are signed 16-bit fixed-point. A 2-bit load counter fills a group of four operands (a, b, c, d). When the fourth operand arrives, the group is frozen together with the radix-2 flag. While the next group is being loaded, the frozen group's four results come out one per load, in counter order. The block therefore accepts and produces one sample per cycle in steady state. With the flag low, the group is one radix-4 butterfly. With it high, the group is two radix-2 butterflies.

Overflow cannot occur. Every add stage is computed one bit wider and then halved by an arithmetic right shift, so radix-4 results carry a scale of 1/4 and radix-2 results a scale of 1/2. Multiplication by ±j is done by swapping and negating the real and imaginary parts. The control is a two-state machine:

- ST_FILL means no complete group is held.
- ST_STREAM means a frozen group is available and results are emitted.

The transitions are:

- FILL_TO_STREAM: a load when the counter is 3.
- STREAM_TO_FILL: a clear.
- FILL_HOLD: a clear, or any cycle that does not complete a group.
- STREAM_HOLD: any cycle without a clear.

Top module: `serial_bfly`

## Requirements
- R1: While reset is active and after its release, `out_valid` is 0 and `out_data` is 0 until a result is produced.
- R2: Sample and result words carry a signed 16-bit real part in bits 15:0 and a signed 16-bit imaginary part in bits 31:16.
- R3: The load counter starts at 0 and advances by one, modulo 4, on each load. No result is produced until four loads have completed a group.
- R4: With the flag low at group completion, the results for counter values 0, 1, 2 and 3 are (a+b+c+d)/4, (a−jb−c+jd)/4, (a−b+c−d)/4 and (a+jb−c−jd)/4.
- R5: With the flag high at group completion, the results for counter values 0, 1, 2 and 3 are (a+b)/2, (a−b)/2, (c+d)/2 and (c−d)/2.
- R6: Once a group is held, each load that is not cleared raises `out_valid` for exactly the next cycle. The result shown is the one selected by the counter value before that load.
- R7: The flag is sampled only on the load that completes a group. Changes to it during the other loads have no effect on the results.
- R8: A clear returns the counter to 0, discards both the partial and the held group, and wins over a load in the same cycle (that load is ignored). `out_valid` stays 0 until a new group is complete and followed by a load.
- R9: The load that completes a new group while a group is held emits the old group's counter-3 result in the same cycle as it installs the new group.
- R10: In a cycle without an accepted load from ST_STREAM, `out_valid` is 0 on the next cycle and `out_data` keeps its value.
- R11: Each halving is an arithmetic right shift of a 17-bit sum, truncating toward minus infinity. Full-scale inputs such as all 32767 or all −32768 reproduce themselves without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Counter and group clear, has priority over `ld` |
| ld | input | 1 | Load strobe for `din` |
| din | input | 32 | Complex sample (imaginary in high half) |
| rx2 | input | 1 | Radix-2 select, sampled on group completion |
| out_data | output | 32 | Complex butterfly result |
| out_valid | output | 1 | High for one cycle per produced result |

## Verification
Two functions can land in one cycle. The first pair is emitting the held group's last result and installing a new group from the completing load. The bench provokes this by loading groups back to back and judges it by comparing that output against the old group's counter-3 term, and the following outputs against the new group. The second pair is clear and load. The bench asserts both in one cycle and checks that `out_valid` stays low and that a fresh four-load fill is needed before any result appears.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    // Control states of the operand buffer
    typedef enum logic {
        ST_FILL   = 1'b0,
        ST_STREAM = 1'b1
    } sbf_state_e;

    // Number of operands in one butterfly group
    localparam int unsigned GROUP_N = 4;
    localparam int unsigned CNT_W   = $clog2(GROUP_N);

endpackage

// File: rtl/sbf_hadd.sv
// Halving adder: one bit of growth, then arithmetic shift right by one.
module sbf_hadd #(
    parameter int unsigned W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y
);
    logic signed [W:0] wide_a;
    logic signed [W:0] wide_b;
    logic signed [W:0] sum;

    always_comb begin
        wide_a = {a[W-1], a};
        wide_b = {b[W-1], b};
        sum    = sub ? (wide_a - wide_b) : (wide_a + wide_b);
        y      = sum[W:1];
    end
endmodule

// File: rtl/sbf_opbuf.sv
// Serial operand collector, group freeze and state machine.
module sbf_opbuf
    import sbf_pkg::*;
#(
    parameter int unsigned WW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      ld,
    input  logic [WW-1:0]             din,
    input  logic                      rx2_in,
    output logic [CNT_W-1:0]          cnt,
    output sbf_state_e                state,
    output logic [GROUP_N-1:0][WW-1:0] held,
    output logic                      held_rx2,
    output logic                      take
);
    localparam int unsigned STAGE_N = GROUP_N - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_N - 1);

    sbf_state_e nxt_state;
    logic       completes;
    logic [STAGE_N-1:0][WW-1:0] stage_q;

    assign take      = ld && !clr;
    assign completes = take && (cnt == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= nxt_state;
        end
    end

    // Next-state decode
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_FILL: begin
                if (clr) begin
                    nxt_state = ST_FILL;
                end else if (completes) begin
                    nxt_state = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (clr) begin
                    nxt_state = ST_FILL;
                end
            end
            default: nxt_state = ST_FILL;
        endcase
    end

    // Load counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Staging slots for the first three operands of a group
    for (genvar s = 0; s < STAGE_N; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (take && (cnt == CNT_W'(s))) begin
                stage_q[s] <= din;
            end
        end
    end

    // Frozen group, replaced on each completing load
    for (genvar h = 0; h < GROUP_N; h++) begin : g_held
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[h] <= '0;
            end else if (completes) begin
                if (h == GROUP_N - 1) begin
                    held[h] <= din;
                end else begin
                    held[h] <= stage_q[h];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_rx2 <= 1'b0;
        end else if (completes) begin
            held_rx2 <= rx2_in;
        end
    end
endmodule

// File: rtl/sbf_core.sv
// Two-stage halving butterfly; only the term picked by sel is formed.
module sbf_core
    import sbf_pkg::*;
#(
    parameter int unsigned PW = 16
) (
    input  logic [GROUP_N-1:0][2*PW-1:0] op,
    input  logic                         rx2,
    input  logic [CNT_W-1:0]             sel,
    output logic [2*PW-1:0]              y
);
    localparam int unsigned LANES = 2;

    logic signed [PW-1:0] s1_x   [LANES][2];  // [lane][re/im]
    logic signed [PW-1:0] s1_z   [LANES][2];
    logic signed [PW-1:0] s1_sum [LANES][2];
    logic signed [PW-1:0] s1_dif [LANES][2];

    // First stage: radix-2 pairs (a,b),(c,d); radix-4 pairs (a,c),(b,d)
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar p = 0; p < 2; p++) begin : g_part
            always_comb begin
                if (rx2) begin
                    s1_x[l][p] = op[2*l][p*PW +: PW];
                    s1_z[l][p] = op[2*l+1][p*PW +: PW];
                end else begin
                    s1_x[l][p] = op[l][p*PW +: PW];
                    s1_z[l][p] = op[l+2][p*PW +: PW];
                end
            end
            sbf_hadd #(.W(PW)) u_sum (
                .a(s1_x[l][p]), .b(s1_z[l][p]), .sub(1'b0), .y(s1_sum[l][p])
            );
            sbf_hadd #(.W(PW)) u_dif (
                .a(s1_x[l][p]), .b(s1_z[l][p]), .sub(1'b1), .y(s1_dif[l][p])
            );
        end
    end

    // Second stage operand steering for the radix-4 term
    logic signed [PW-1:0] s2_x [2];
    logic signed [PW-1:0] s2_z [2];
    logic                 s2_sub [2];
    logic signed [PW-1:0] s2_y [2];

    always_comb begin
        unique case (sel)
            2'd0: begin
                s2_x[0] = s1_sum[0][0]; s2_z[0] = s1_sum[1][0]; s2_sub[0] = 1'b0;
                s2_x[1] = s1_sum[0][1]; s2_z[1] = s1_sum[1][1]; s2_sub[1] = 1'b0;
            end
            2'd1: begin
                // (a-c) - j(b-d): re + t.im, im - t.re
                s2_x[0] = s1_dif[0][0]; s2_z[0] = s1_dif[1][1]; s2_sub[0] = 1'b0;
                s2_x[1] = s1_dif[0][1]; s2_z[1] = s1_dif[1][0]; s2_sub[1] = 1'b1;
            end
            2'd2: begin
                s2_x[0] = s1_sum[0][0]; s2_z[0] = s1_sum[1][0]; s2_sub[0] = 1'b1;
                s2_x[1] = s1_sum[0][1]; s2_z[1] = s1_sum[1][1]; s2_sub[1] = 1'b1;
            end
            default: begin
                // (a-c) + j(b-d): re - t.im, im + t.re
                s2_x[0] = s1_dif[0][0]; s2_z[0] = s1_dif[1][1]; s2_sub[0] = 1'b1;
                s2_x[1] = s1_dif[0][1]; s2_z[1] = s1_dif[1][0]; s2_sub[1] = 1'b0;
            end
        endcase
    end

    for (genvar p = 0; p < 2; p++) begin : g_s2
        sbf_hadd #(.W(PW)) u_s2 (
            .a(s2_x[p]), .b(s2_z[p]), .sub(s2_sub[p]), .y(s2_y[p])
        );
    end

    // Term selection
    always_comb begin
        if (rx2) begin
            unique case (sel)
                2'd0:    y = {s1_sum[0][1], s1_sum[0][0]};
                2'd1:    y = {s1_dif[0][1], s1_dif[0][0]};
                2'd2:    y = {s1_sum[1][1], s1_sum[1][0]};
                default: y = {s1_dif[1][1], s1_dif[1][0]};
            endcase
        end else begin
            y = {s2_y[1], s2_y[0]};
        end
    end
endmodule

// File: rtl/serial_bfly.sv
module serial_bfly
    import sbf_pkg::*;
#(
    parameter int unsigned PART_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  ld,
    input  logic [2*PART_W-1:0]   din,
    input  logic                  rx2,
    output logic [2*PART_W-1:0]   out_data,
    output logic                  out_valid
);
    localparam int unsigned WW = 2 * PART_W;

    logic [CNT_W-1:0]           cnt;
    sbf_state_e                 state;
    logic [GROUP_N-1:0][WW-1:0] held;
    logic                       held_rx2;
    logic                       take;
    logic [WW-1:0]              term;

    sbf_opbuf #(.WW(WW)) u_opbuf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .din(din),
        .rx2_in(rx2), .cnt(cnt), .state(state), .held(held),
        .held_rx2(held_rx2), .take(take)
    );

    sbf_core #(.PW(PART_W)) u_core (
        .op(held), .rx2(held_rx2), .sel(cnt), .y(term)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take && (state == ST_STREAM);
            if (take && (state == ST_STREAM)) begin
                out_data <= term;
            end
        end
    end
endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
    parameter int unsigned WW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          ld,
    input logic [WW-1:0] out_data,
    input logic          out_valid
);
    logic [2:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (clr) begin
            seen <= '0;
        end else if (ld && seen != 3'd7) begin
            seen <= seen + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_valid_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(ld && !clr));

    p_full_group_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(seen) >= 3'd4);

    p_clr_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid);

    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld || clr) |=> (!out_valid && $stable(out_data)));
endmodule

bind serial_bfly sbf_chk #(.WW(2*PART_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld),
    .out_data(out_data), .out_valid(out_valid)
);

// File: tb/tb_serial_bfly.sv
module tb_serial_bfly;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ld = 1'b0;
    logic [31:0] din = '0;
    logic        rx2 = 1'b0;
    logic [31:0] out_data;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model of the grouping rules
    int          m_cnt = 0;
    bit          m_have = 1'b0;
    logic [31:0] m_stage [3];
    logic [31:0] m_held [4];
    bit          m_hrx2 = 1'b0;
    logic [31:0] m_last = '0;

    serial_bfly dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .din(din),
        .rx2(rx2), .out_data(out_data), .out_valid(out_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] cw(int re, int im);
        logic [15:0] r16 = re[15:0];
        logic [15:0] i16 = im[15:0];
        return {i16, r16};
    endfunction

    function automatic int re_of(logic [31:0] w);
        return int'($signed(w[15:0]));
    endfunction

    function automatic int im_of(logic [31:0] w);
        return int'($signed(w[31:16]));
    endfunction

    function automatic int h(int x);
        return x >>> 1;
    endfunction

    // Expected term from R4/R5/R11
    function automatic logic [31:0] ref_term(logic [31:0] a, logic [31:0] b,
                                             logic [31:0] c, logic [31:0] d,
                                             bit r2, int k);
        int ar = re_of(a), ai = im_of(a), br = re_of(b), bi = im_of(b);
        int cr = re_of(c), ci = im_of(c), dr = re_of(d), di = im_of(d);
        int sr, si, dfr, dfi, tr, ti, ur, ui;
        if (r2) begin
            case (k)
                0: return cw(h(ar + br), h(ai + bi));
                1: return cw(h(ar - br), h(ai - bi));
                2: return cw(h(cr + dr), h(ci + di));
                default: return cw(h(cr - dr), h(ci - di));
            endcase
        end
        sr = h(ar + cr); si = h(ai + ci);
        dfr = h(ar - cr); dfi = h(ai - ci);
        tr = h(br + dr); ti = h(bi + di);
        ur = h(br - dr); ui = h(bi - di);
        case (k)
            0: return cw(h(sr + tr), h(si + ti));
            1: return cw(h(dfr + ui), h(dfi - ur));
            2: return cw(h(sr - tr), h(si - ti));
            default: return cw(h(dfr - ui), h(dfi + ur));
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act_d, logic act_v,
                         logic [31:0] exp_d, logic exp_v);
        n_chk++;
        if (act_v !== exp_v || (exp_v && act_d !== exp_d) || (!exp_v && act_d !== m_last)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, act_v, act_d, exp_v, exp_v ? exp_d : m_last);
        end
        if (exp_v) m_last = exp_d;
    endtask

    // Drive one sample at a falling edge, check at the next falling edge
    task automatic push(logic [31:0] w, bit r2, string tag);
        logic [31:0] e;
        bit          ev;
        ev = m_have;
        e  = m_have ? ref_term(m_held[0], m_held[1], m_held[2], m_held[3], m_hrx2, m_cnt) : m_last;
        ld = 1'b1; din = w; rx2 = r2;
        if (m_cnt < 3) begin
            m_stage[m_cnt] = w;
        end else begin
            m_held[0] = m_stage[0]; m_held[1] = m_stage[1];
            m_held[2] = m_stage[2]; m_held[3] = w;
            m_hrx2 = r2; m_have = 1'b1;
        end
        m_cnt = (m_cnt + 1) % 4;
        @(negedge clk);
        ld = 1'b0;
        check(tag, out_data, out_valid, e, ev);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        check(tag, out_data, out_valid, '0, 1'b0);
    endtask

    task automatic clear(bit with_ld, string tag);
        clr = 1'b1; ld = with_ld; din = 32'hDEAD_BEEF;
        m_cnt = 0; m_have = 1'b0;
        @(negedge clk);
        clr = 1'b0; ld = 1'b0;
        check(tag, out_data, out_valid, '0, 1'b0);
    endtask

    task automatic group(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [31:0] d, bit r2, string tag);
        push(a, r2, tag); push(b, r2, tag); push(c, r2, tag); push(d, r2, tag);
    endtask

    task automatic t_reset;
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
        end
    endtask

    task automatic t_radix4;
        // R3: first group emits nothing; R4/R2: next group emits the four terms
        group(cw(100, -20), cw(30, 40), cw(-50, 7), cw(9, -13), 1'b0, "R3 fill");
        group(cw(1000, 2000), cw(-300, 150), cw(77, -5), cw(-1, 1), 1'b0, "R4 radix-4");
        group(cw(3, 5), cw(-7, 11), cw(13, -17), cw(19, 23), 1'b0, "R9 back-to-back R4");
    endtask

    task automatic t_radix2;
        group(cw(-1000, 500), cw(250, -125), cw(40, 41), cw(-42, 43), 1'b1, "R5 radix-2 group");
        group(cw(1, 1), cw(2, 2), cw(3, 3), cw(4, 4), 1'b0, "R5 radix-2 out");
    endtask

    task automatic t_rx2_mid;
        // R7: flag toggles on non-completing loads
        push(cw(11, 12), 1'b1, "R7"); push(cw(13, 14), 1'b1, "R7");
        push(cw(15, 16), 1'b1, "R7"); push(cw(-17, 18), 1'b0, "R7");
        group(cw(0, 0), cw(0, 0), cw(0, 0), cw(0, 0), 1'b0, "R7 flag at completion");
    endtask

    task automatic t_extremes;
        // R11: full-scale values survive both halvings
        group(cw(32767, -32768), cw(32767, -32768), cw(32767, -32768), cw(32767, -32768), 1'b0, "R11 full scale");
        group(cw(-32768, 32767), cw(32767, -32768), cw(-32768, 32767), cw(32767, -32768), 1'b0, "R11 alternating");
        group(cw(-1, -3), cw(0, 0), cw(0, 0), cw(0, 0), 1'b1, "R11 truncation");
        group(cw(0, 0), cw(0, 0), cw(0, 0), cw(0, 0), 1'b1, "R11 flush");
    endtask

    task automatic t_idle_gaps;
        push(cw(5, 6), 1'b0, "R10"); idle("R10 gap"); push(cw(7, 8), 1'b0, "R10");
        idle("R10 gap"); idle("R10 gap"); push(cw(9, 10), 1'b0, "R10");
        push(cw(11, 12), 1'b0, "R10");
    endtask

    task automatic t_clear;
        // R8: clear mid-group, then clear together with a load
        push(cw(1, 1), 1'b0, "R8"); push(cw(2, 2), 1'b0, "R8");
        clear(1'b0, "R8 clear");
        push(cw(100, 0), 1'b0, "R8 refill"); push(cw(0, 100), 1'b0, "R8 refill");
        clear(1'b1, "R8 clear beats load");
        group(cw(4, 8), cw(-4, 8), cw(4, -8), cw(-4, -8), 1'b0, "R8 fresh fill");
        group(cw(0, 0), cw(0, 0), cw(0, 0), cw(0, 0), 1'b1, "R8 fresh out");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_radix4();
        t_radix2();
        t_rx2_mid();
        t_extremes();
        t_idle_gaps();
        t_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule